// File: doc/BRIEF.md
# Snooping Five-State Coherence Controller

This block keeps the coherence state of a small set of lines held by one private cache that sits on a shared snooping bus. Each line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. The local processor sends read, write and evict requests one at a time. The controller decides whether a request can finish locally or needs a bus transaction. When it needs one, it raises a request, waits for a grant and then updates the line. Transactions that other caches put on the bus arrive on a snoop port. Against these, the controller moves its lines to the correct state, says whether it holds a copy, and says whether it supplies the data.

Two states go beyond the usual three. Owned lets dirty data be shared without first updating memory, and the owner stays the only cache that supplies that data. Exclusive lets a clean private line be written with no bus traffic. On a read fill, the shared input returned by the other caches chooses between Exclusive and Shared. A pending bus command is worked out again in every cycle from the present line state. A snoop that removes the line while a request waits therefore changes the command that will be issued.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0), cpu_ready is high and bus_req is low. State codes: Invalid 0, Shared 1, Exclusive 2, Owned 3, Modified 4.
- R2: A read of an Invalid line (cpu_op 0) requests bus command 1 (read). At the grant the line fills as Shared if bus_shared is high and as Exclusive if it is low.
- R3: A read of a valid line, or a write to a Modified line, uses no bus and raises cpu_done in the cycle after the request is accepted.
- R4: A write (cpu_op 1) to an Exclusive line moves it to Modified without any bus request.
- R5: A write to a Shared or Owned line requests bus command 3 (upgrade) with bus_inv high. At the grant the line becomes Modified.
- R6: A write to an Invalid line requests bus command 2 (read for ownership) with bus_inv high. At the grant the line becomes Modified.
- R7: A snooped read (snp_cmd 1) of a Modified or Owned line raises snp_supply in the same cycle. The line is left in Owned.
- R8: A snooped read of an Exclusive line moves it to Shared. A snooped read of an Exclusive, Shared or Invalid line never raises snp_supply. snp_has_copy is high whenever the snooped line is not Invalid.
- R9: A snooped read for ownership (2) or upgrade (3) invalidates the line. snp_supply is raised for command 2 when the line is Modified or Owned, and never for command 3.
- R10: Evicting (cpu_op 2) a Modified or Owned line requests bus command 0 (writeback) with wb_req high and then leaves the line Invalid. Evicting an Exclusive, Shared or Invalid line goes to Invalid with no bus request.
- R11: While a request waits for its grant, the command follows the line's present state: a pending upgrade whose line is invalidated by a snoop becomes a read for ownership.
- R12: cpu_done is high for exactly one cycle per completed request. cpu_ready is low while a bus request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Local request, accepted when cpu_ready is high |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_idx | input | IW | Line index of the request; also selects cpu_state |
| cpu_ready | output | 1 | No request outstanding |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_state | output | 3 | Coherence state of line cpu_idx |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 writeback, 1 read, 2 read for ownership, 3 upgrade |
| bus_inv | output | 1 | Request invalidates copies in other caches |
| wb_req | output | 1 | Request is a writeback |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared | input | 1 | Another cache holds the line, sampled at grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_idx | input | IW | Line index of the snooped transaction |
| snp_supply | output | 1 | This cache drives the data for the snoop |
| snp_has_copy | output | 1 | This cache holds the snooped line |

## Verification
Some rules hold in every cycle and the assertions check them there. A read fill lands in Exclusive or Shared according to the sampled shared input. A write completion always leaves the line Modified. A snooped read demotes Modified to Owned. An invalidating snoop clears the line unless a local update of the same line wins the edge. A local hit finishes one cycle later. Other behaviour needs a planned order of events, so only the directed scenarios can show it. These are the full chains across states, such as Exclusive to Modified to Owned to Modified, and the silent evictions. One more is a pending upgrade that turns into a read for ownership after a snoop invalidates its line.

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl #(
  parameter int NLINES = 4,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_op,
  input  logic [IW-1:0] cpu_idx,
  output logic          cpu_ready,
  output logic          cpu_done,
  output logic [2:0]    cpu_state,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic          bus_inv,
  output logic          wb_req,
  input  logic          bus_gnt,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [IW-1:0] snp_idx,
  output logic          snp_supply,
  output logic          snp_has_copy
);
  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2;
  localparam logic [1:0] C_WB = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_UPG = 2'd3;

  logic [2:0]    st [NLINES];
  logic          busy_q;
  logic [1:0]    op_q;
  logic [IW-1:0] idx_q;

  logic [1:0]    sel_op;
  logic [IW-1:0] sel_idx;
  logic [2:0]    cur, nxt, snp_st, snp_nxt;
  logic          need, local_wr;

  assign sel_op  = busy_q ? op_q  : cpu_op;
  assign sel_idx = busy_q ? idx_q : cpu_idx;
  assign cur     = st[sel_idx];
  assign snp_st  = st[snp_idx];

  always_comb begin
    need    = 1'b0;
    bus_cmd = C_RD;
    nxt     = cur;
    unique case (sel_op)
      OP_WR: begin
        nxt = ST_M;
        if (cur == ST_I) begin
          need = 1'b1; bus_cmd = C_RDX;
        end else if (cur == ST_S || cur == ST_O) begin
          need = 1'b1; bus_cmd = C_UPG;
        end
      end
      OP_EV: begin
        nxt = ST_I;
        if (cur == ST_M || cur == ST_O) begin
          need = 1'b1; bus_cmd = C_WB;
        end
      end
      default: begin
        if (cur == ST_I) begin
          need = 1'b1;
          nxt  = bus_shared ? ST_S : ST_E;
        end
      end
    endcase
  end

  always_comb begin
    snp_nxt = snp_st;
    if (snp_cmd == C_RD) begin
      if (snp_st == ST_M) snp_nxt = ST_O;
      else if (snp_st == ST_E) snp_nxt = ST_S;
    end else if (snp_cmd == C_RDX || snp_cmd == C_UPG) begin
      snp_nxt = ST_I;
    end
  end

  assign local_wr     = busy_q ? (!need || bus_gnt) : (cpu_req && !need);
  assign cpu_ready    = !busy_q;
  assign cpu_state    = st[cpu_idx];
  assign bus_req      = busy_q && need;
  assign bus_inv      = bus_req && (bus_cmd == C_RDX || bus_cmd == C_UPG);
  assign wb_req       = bus_req && (bus_cmd == C_WB);
  assign snp_has_copy = snp_valid && (snp_st != ST_I);
  assign snp_supply   = snp_valid && (snp_cmd == C_RD || snp_cmd == C_RDX) &&
                        (snp_st == ST_M || snp_st == ST_O);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st[i] <= ST_I;
      busy_q   <= 1'b0;
      op_q     <= OP_RD;
      idx_q    <= '0;
      cpu_done <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      if (snp_valid) st[snp_idx] <= snp_nxt;
      if (!busy_q && cpu_req) begin
        op_q  <= cpu_op;
        idx_q <= cpu_idx;
        if (need) busy_q <= 1'b1;
      end
      if (local_wr) begin
        st[sel_idx] <= nxt;
        cpu_done    <= 1'b1;
        busy_q      <= 1'b0;
      end
    end
  end

  assert_fill_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == C_RD) |=>
      (st[idx_q] == ($past(bus_shared) ? ST_S : ST_E)));

  assert_hit_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cpu_req && cpu_op == OP_RD && st[cpu_idx] != ST_I) |=> (cpu_done && cpu_ready));

  assert_write_modified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && op_q == OP_WR) |-> (st[idx_q] == ST_M));

  assert_snoop_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == C_RD && snp_st == ST_M && !(local_wr && sel_idx == snp_idx))
      |=> (st[$past(snp_idx)] == ST_O));

  assert_snoop_inval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_cmd == C_RDX || snp_cmd == C_UPG) && !(local_wr && sel_idx == snp_idx))
      |=> (st[$past(snp_idx)] == ST_I));
endmodule

// File: tb/sim_moesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_line_ctrl;
  localparam int IW = 2;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0; logic [1:0] cpu_op = 0; logic [IW-1:0] cpu_idx = 0;
  logic cpu_ready, cpu_done; logic [2:0] cpu_state;
  logic bus_req, bus_inv, wb_req; logic [1:0] bus_cmd;
  logic bus_gnt = 0, bus_shared = 0;
  logic snp_valid = 0; logic [1:0] snp_cmd = 0; logic [IW-1:0] snp_idx = 0;
  logic snp_supply, snp_has_copy;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  moesi_line_ctrl #(.NLINES(4)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic local_op(input logic [1:0] op, input int idx, input bit sh, input bit use_bus,
                          input logic [1:0] cmd, input logic [2:0] exp_st, input string tag);
    @(negedge clk); cpu_req = 1; cpu_op = op; cpu_idx = idx[IW-1:0];
    @(negedge clk); cpu_req = 0;
    if (use_bus) begin
      chk(bus_req == 1, {tag, " bus_req"}, bus_req, 1);
      chk(bus_cmd == cmd, {tag, " bus_cmd"}, bus_cmd, cmd);
      chk(bus_inv == (cmd == 2 || cmd == 3), {tag, " bus_inv"}, bus_inv, (cmd == 2 || cmd == 3));
      chk(wb_req == (cmd == 0), {tag, " wb_req"}, wb_req, (cmd == 0));
      chk(cpu_ready == 0, "R12 ready low while pending", cpu_ready, 0);
      bus_gnt = 1; bus_shared = sh;
      @(negedge clk); bus_gnt = 0; bus_shared = 0;
    end else begin
      chk(bus_req == 0, {tag, " no bus"}, bus_req, 0);
    end
    chk(cpu_done == 1, {tag, " done"}, cpu_done, 1);
    chk(cpu_state == exp_st, {tag, " state"}, cpu_state, exp_st);
    @(negedge clk);
    chk(cpu_done == 0 && cpu_ready == 1, "R12 done single pulse", cpu_done, 0);
  endtask

  task automatic snoop(input logic [1:0] cmd, input int idx, input bit exp_sup, input bit exp_hit,
                       input logic [2:0] exp_st, input string tag);
    @(negedge clk); snp_valid = 1; snp_cmd = cmd; snp_idx = idx[IW-1:0];
    #1;
    chk(snp_supply == exp_sup, {tag, " supply"}, snp_supply, exp_sup);
    chk(snp_has_copy == exp_hit, "R8 has_copy", snp_has_copy, exp_hit);
    @(negedge clk); snp_valid = 0; cpu_idx = idx[IW-1:0];
    #1;
    chk(cpu_state == exp_st, {tag, " state"}, cpu_state, exp_st);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cpu_idx = i[IW-1:0]; #1;
      chk(cpu_state == 0, "R1 line invalid", cpu_state, 0);
    end
    chk(cpu_ready == 1 && bus_req == 0, "R1 idle", cpu_ready, 1);
  endtask

  task automatic t_exclusive_chain();
    local_op(0, 0, 0, 1, 1, 2, "R2 read fill exclusive");
    local_op(0, 0, 0, 0, 0, 2, "R3 read hit");
    local_op(1, 0, 0, 0, 0, 4, "R4 silent write");
    local_op(1, 0, 0, 0, 0, 4, "R3 write hit modified");
    snoop(1, 0, 1, 1, 3, "R7 snoop read modified");
    snoop(1, 0, 1, 1, 3, "R7 snoop read owned");
    local_op(1, 0, 0, 1, 3, 4, "R5 upgrade from owned");
  endtask

  task automatic t_shared_chain();
    local_op(0, 1, 1, 1, 1, 1, "R2 read fill shared");
    snoop(1, 1, 0, 1, 1, "R8 snoop read shared");
    local_op(1, 1, 0, 1, 3, 4, "R5 upgrade from shared");
  endtask

  task automatic t_write_miss();
    local_op(1, 2, 0, 1, 2, 4, "R6 write miss");
    snoop(2, 2, 1, 1, 0, "R9 snoop rdx on modified");
    snoop(1, 2, 0, 0, 0, "R8 snoop read invalid");
  endtask

  task automatic t_snoop_exclusive();
    local_op(0, 3, 0, 1, 1, 2, "R2 fill exclusive line3");
    snoop(1, 3, 0, 1, 1, "R8 snoop read exclusive");
    snoop(3, 3, 0, 1, 0, "R9 snoop upgrade");
  endtask

  task automatic t_evict();
    local_op(2, 1, 0, 1, 0, 0, "R10 evict modified");
    snoop(1, 0, 1, 1, 3, "R7 demote before evict");
    local_op(2, 0, 0, 1, 0, 0, "R10 evict owned");
    local_op(0, 3, 1, 1, 1, 1, "R2 refill shared");
    local_op(2, 3, 0, 0, 0, 0, "R10 evict shared silent");
    local_op(0, 3, 0, 1, 1, 2, "R2 refill exclusive");
    local_op(2, 3, 0, 0, 0, 0, "R10 evict exclusive silent");
    local_op(2, 2, 0, 0, 0, 0, "R10 evict invalid");
  endtask

  task automatic t_race();
    local_op(0, 1, 1, 1, 1, 1, "R2 fill shared for race");
    @(negedge clk); cpu_req = 1; cpu_op = 1; cpu_idx = 1;
    @(negedge clk); cpu_req = 0;
    chk(bus_req == 1 && bus_cmd == 3, "R11 pending upgrade", bus_cmd, 3);
    snp_valid = 1; snp_cmd = 3; snp_idx = 1;
    @(negedge clk); snp_valid = 0;
    chk(bus_req == 1 && bus_cmd == 2, "R11 became rdx", bus_cmd, 2);
    chk(bus_inv == 1, "R11 inv kept", bus_inv, 1);
    chk(cpu_state == 0, "R11 line invalidated", cpu_state, 0);
    bus_gnt = 1;
    @(negedge clk); bus_gnt = 0;
    chk(cpu_done == 1, "R11 done", cpu_done, 1);
    chk(cpu_state == 4, "R11 modified", cpu_state, 4);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_exclusive_chain();
    t_shared_chain();
    t_write_miss();
    t_snoop_exclusive();
    t_evict();
    t_race();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule